// File: doc/BRIEF.md
# Cell Clock Phase Aligner

This block sits on the transceiver side of a serial link to a central switch. It runs after word synchronization, and only when cell mode is enabled. During this phase the switch loops the port back onto itself. The block transmits ALIGN words. Each ALIGN word carries, in its lowest bit, a marker that is set on the word that starts a local transmit cell. The looped-back words return through the switch, which tags them with a flag for the master cell clock.

The block compares the word slot in which its own marker comes back with the slot flagged as the master cell start. On a mismatch it delays its transmit cell clock by one word. It then ignores returning markers for one full cell period, so that markers sent at the old phase are not counted. After two matches in a row it raises the aligned flag. At that point it sends IDLE words and keeps the transmit cell clock at the phase it found. This cancels the round-trip pipeline delay between the transceiver and the switch.

Top module: `cell_phase_aligner`

## Requirements
- R1: While `rst` is high, `tx_cell_start` and `cell_aligned` are 0 and `tx_word` equals `IDLE_WORD` (default 32'h7E817E81) from the first clock edge on.
- R2: While `cell_mode_en` or `word_sync_done` is low, the block ignores `rx_word` and `rx_cclk`. On the next edge, `tx_cell_start` and `cell_aligned` are 0 and `tx_word` is `IDLE_WORD`.
- R3: The block becomes active when both enables are high. The first `tx_cell_start` pulse comes one cycle after the first active edge. While the block is active and not aligned, `tx_word` is `{ALIGN_TAG, m}`, where `m` (bit 0) equals `tx_cell_start` in the same cycle. The default `ALIGN_TAG` is 31'h4B3C2D1E. With no adjustment, `tx_cell_start` pulses once every `CELL_WORDS` cycles. `CELL_WORDS` must be at least 8.
- R4: A looped-back marker is a received word equal to `{ALIGN_TAG,1'b1}`. When one arrives without `rx_cclk`, the transmit cell clock is delayed by exactly one word: a single gap between start pulses becomes `CELL_WORDS+1`.
- R5: After each one-word delay, markers are ignored until the delay has been applied and then for `CELL_WORDS` more cycles. Markers still in flight from the old phase therefore cause no extra delay. For a loop delay of up to `2*CELL_WORDS-2` words, the number of delays equals the initial slot offset modulo `CELL_WORDS`.
- R6: `cell_aligned` rises two cycles after a returned marker that coincides with `rx_cclk`, when the marker before it also coincided and the two start pulses were `CELL_WORDS` apart. Once set, it stays set while both enables stay high.
- R7: Once aligned, the block keeps the same phase. Every `tx_cell_start` pulse, delayed by the loop delay, lands on the slot where the master flag arrives.
- R8: When either enable drops, `cell_aligned` clears on the next edge. The search starts again from the beginning on the next activation.
- R9: From the cycle after `cell_aligned` rises, `tx_word` is `IDLE_WORD` and start pulses keep a fixed period of `CELL_WORDS`, with no further adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_mode_en | input | 1 | Cell mode enable |
| word_sync_done | input | 1 | Word synchronization complete |
| rx_word | input | WORD_W | Received word from the switch |
| rx_cclk | input | 1 | Master cell-clock flag for the received word |
| tx_word | output | WORD_W | Transmit word (ALIGN or IDLE) |
| tx_cell_start | output | 1 | Transmit cell-start strobe |
| cell_aligned | output | 1 | Transmit cell clock is phase aligned |

## Verification
The assertions assume a loopback whose delay stays fixed during a search. They also assume that the master flag recurs every `CELL_WORDS` words. They rely on the enables being the only way the search restarts. The stimulus models the switch as a fixed delay line from `tx_word` to `rx_word`, driven by a free-running master slot counter. It sweeps every master slot and every loop delay from 1 to 12 words for the default 8-word cell, which stays within the supported delay window. Between runs it drops one enable or the other, so every search starts from a clean, inactive state.

// File: rtl/cpa_pkg.sv
`timescale 1ns/1ps
package cpa_pkg;
  localparam int unsigned CPA_WORD_W_DEF = 32;
  localparam logic [CPA_WORD_W_DEF-2:0] CPA_ALIGN_TAG_DEF = 31'h4B3C2D1E;
  localparam logic [CPA_WORD_W_DEF-1:0] CPA_IDLE_DEF = 32'h7E817E81;
  localparam int unsigned CPA_MIN_CELL = 8;

  function automatic int unsigned cpa_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cpa_rx_detect.sv
`timescale 1ns/1ps
module cpa_rx_detect #(
  parameter int unsigned WORD_W = 32,
  parameter logic [WORD_W-2:0] ALIGN_TAG = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_cclk,
  output logic              mark_q,
  output logic              cclk_q
);
  localparam logic [WORD_W-1:0] MARK_WORD = {ALIGN_TAG, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      mark_q <= 1'b0;
      cclk_q <= 1'b0;
    end else begin
      mark_q <= (rx_word == MARK_WORD);
      cclk_q <= rx_cclk;
    end
  end

  p_gated_r2: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!mark_q && !cclk_q));
endmodule

// File: rtl/cpa_phase_gen.sv
`timescale 1ns/1ps
module cpa_phase_gen #(
  parameter int unsigned CELL_WORDS = 8,
  parameter int unsigned WORD_W = 32,
  parameter logic [WORD_W-2:0] ALIGN_TAG = '0,
  parameter logic [WORD_W-1:0] IDLE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              slip_pend,
  input  logic              aligned,
  output logic              slip_taken,
  output logic              start_q,
  output logic [WORD_W-1:0] word_q
);
  localparam int unsigned PW = cpa_pkg::cpa_cnt_w(CELL_WORDS);
  localparam logic [PW-1:0] LAST = PW'(CELL_WORDS - 1);

  logic [PW-1:0] phase;
  logic          at_last;
  logic          wrap;

  assign at_last    = (phase == LAST);
  assign slip_taken = active && at_last && slip_pend;
  assign wrap       = at_last && !slip_pend;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      phase   <= LAST;
      start_q <= 1'b0;
      word_q  <= IDLE_WORD;
    end else begin
      if (!at_last)
        phase <= phase + 1'b1;
      else if (wrap)
        phase <= '0;
      start_q <= wrap;
      word_q  <= aligned ? IDLE_WORD : {ALIGN_TAG, wrap};
    end
  end

  p_idle_off_r2: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!start_q && word_q == IDLE_WORD));
  p_strobe_sparse_r3: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  p_idle_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    (aligned && active) |=> (word_q == IDLE_WORD));
endmodule

// File: rtl/cpa_align_ctl.sv
`timescale 1ns/1ps
module cpa_align_ctl #(
  parameter int unsigned CELL_WORDS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic mark_q,
  input  logic cclk_q,
  input  logic slip_taken,
  output logic slip_pend,
  output logic aligned
);
  localparam int unsigned HW = cpa_pkg::cpa_cnt_w(CELL_WORDS + 1);

  logic [HW-1:0] hold_cnt;
  logic          first_hit;
  logic          cmp_en;

  assign cmp_en = active && !aligned && !slip_pend && (hold_cnt == '0) && mark_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      hold_cnt  <= '0;
      first_hit <= 1'b0;
      slip_pend <= 1'b0;
      aligned   <= 1'b0;
    end else begin
      if (slip_taken) begin
        slip_pend <= 1'b0;
        hold_cnt  <= HW'(CELL_WORDS);
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
      if (cmp_en) begin
        if (cclk_q) begin
          if (first_hit)
            aligned <= 1'b1;
          first_hit <= 1'b1;
        end else begin
          slip_pend <= 1'b1;
          first_hit <= 1'b0;
        end
      end
    end
  end

  p_off_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !active |=> !aligned);
  p_aligned_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (aligned && active) |=> aligned);
  p_no_pend_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    aligned |-> !slip_pend);
  p_slip_once_r4: assert property (@(posedge clk) disable iff (rst)
    slip_taken |=> !slip_pend);
endmodule

// File: rtl/cell_phase_aligner.sv
`timescale 1ns/1ps
module cell_phase_aligner #(
  parameter int unsigned CELL_WORDS = 8,
  parameter int unsigned WORD_W = cpa_pkg::CPA_WORD_W_DEF,
  parameter logic [WORD_W-2:0] ALIGN_TAG = cpa_pkg::CPA_ALIGN_TAG_DEF,
  parameter logic [WORD_W-1:0] IDLE_WORD = cpa_pkg::CPA_IDLE_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_mode_en,
  input  logic              word_sync_done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_cclk,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_cell_start,
  output logic              cell_aligned
);
  generate
    if (CELL_WORDS < cpa_pkg::CPA_MIN_CELL) begin : g_bad_cell
      $error("CELL_WORDS below minimum cell length (R3)");
    end
  endgenerate

  logic active;
  logic mark_q, cclk_q;
  logic slip_pend, slip_taken;

  assign active = cell_mode_en && word_sync_done;

  cpa_rx_detect #(.WORD_W(WORD_W), .ALIGN_TAG(ALIGN_TAG)) u_rx (
    .clk(clk), .rst(rst), .active(active),
    .rx_word(rx_word), .rx_cclk(rx_cclk),
    .mark_q(mark_q), .cclk_q(cclk_q)
  );

  cpa_phase_gen #(.CELL_WORDS(CELL_WORDS), .WORD_W(WORD_W),
                  .ALIGN_TAG(ALIGN_TAG), .IDLE_WORD(IDLE_WORD)) u_gen (
    .clk(clk), .rst(rst), .active(active),
    .slip_pend(slip_pend), .aligned(cell_aligned),
    .slip_taken(slip_taken), .start_q(tx_cell_start), .word_q(tx_word)
  );

  cpa_align_ctl #(.CELL_WORDS(CELL_WORDS)) u_ctl (
    .clk(clk), .rst(rst), .active(active),
    .mark_q(mark_q), .cclk_q(cclk_q), .slip_taken(slip_taken),
    .slip_pend(slip_pend), .aligned(cell_aligned)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!tx_cell_start && !cell_aligned && tx_word == IDLE_WORD));
endmodule

// File: tb/cell_phase_aligner_test.sv
`timescale 1ns/1ps
module cell_phase_aligner_test;
  localparam int L = 8;
  localparam int W = 32;
  localparam logic [W-2:0] ATAG = 31'h4B3C2D1E;
  localparam logic [W-1:0] IDLE = 32'h7E817E81;
  localparam logic [W-1:0] AW0 = {ATAG, 1'b0};
  localparam logic [W-1:0] AW1 = {ATAG, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0, sync = 1'b0;
  logic [W-1:0] rx_word, tx_word;
  logic rx_cclk, tx_cell_start, cell_aligned;
  logic inj_en = 1'b0, inj_cclk = 1'b0;
  logic [W-1:0] inj_word = '0;
  logic [W-1:0] pipe [0:15];
  int dly = 1, mslot = 0, mcnt = 0;
  int n_chk = 0, n_fail = 0;
  bit sh [64];
  bit mh [64];

  always #4 clk = ~clk;

  cell_phase_aligner uut (
    .clk(clk), .rst(rst), .cell_mode_en(mode), .word_sync_done(sync),
    .rx_word(rx_word), .rx_cclk(rx_cclk),
    .tx_word(tx_word), .tx_cell_start(tx_cell_start), .cell_aligned(cell_aligned)
  );

  always_ff @(posedge clk) begin
    pipe[0] <= tx_word;
    for (int i = 1; i < 16; i++) pipe[i] <= pipe[i-1];
    mcnt <= (mcnt == L-1) ? 0 : mcnt + 1;
  end

  assign rx_word = inj_en ? inj_word : pipe[dly-1];
  assign rx_cclk = inj_en ? inj_cclk : (mcnt == mslot);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_one(input int m, input int d, input bit drop_mode);
    int t, last, r0, slips, k, s;
    bit first, got;
    t = 0; last = 0; r0 = 0; slips = 0; k = 0; first = 1; got = 0;
    for (int i = 0; i < 64; i++) begin sh[i] = 0; mh[i] = 0; end
    mslot = m; dly = d;
    mode = 1'b1; sync = 1'b1;
    while (!got && t < 600) begin
      @(negedge clk); t++;
      sh[t % 64] = tx_cell_start;
      mh[t % 64] = tx_cell_start && (((mcnt + d) % L) == m);
      if (tx_cell_start) begin
        if (first) begin
          r0 = (mcnt + d) % L; first = 0;
          chk(t == 1, "R3 first strobe cycle", t, 1);
        end else begin
          chk((t - last == L) || (t - last == L + 1), "R4 strobe gap", t - last, L);
          if (t - last == L + 1) slips++;
        end
        last = t;
      end
      if (cell_aligned) begin
        got = 1; k = t;
      end else begin
        chk(tx_word == (tx_cell_start ? AW1 : AW0), "R3 align word", tx_word,
            tx_cell_start ? AW1 : AW0);
      end
    end
    chk(got, "R6 aligned within bound", got, 1);
    chk(slips == (((m - r0) % L) + L) % L, "R4/R5 slip count", slips, (((m - r0) % L) + L) % L);
    s = k - d - 2;
    chk(got && s - L > 0 && sh[s % 64] && mh[s % 64] && sh[(s - L) % 64] && mh[(s - L) % 64],
        "R6 two matches before rise", s, k);
    for (int c = 0; c < 3 * L; c++) begin
      @(negedge clk); t++;
      chk(cell_aligned, "R6 stays aligned", cell_aligned, 1);
      chk(tx_word == IDLE, "R9 idle after aligned", tx_word, IDLE);
      if (tx_cell_start) begin
        chk(t - last == L, "R9 steady period", t - last, L);
        chk(((mcnt + d) % L) == m, "R7 phase locked", (mcnt + d) % L, m);
        last = t;
      end
    end
    if (drop_mode) mode = 1'b0; else sync = 1'b0;
    @(negedge clk);
    chk(!cell_aligned && !tx_cell_start && tx_word == IDLE, "R8 drop clears",
        {cell_aligned, tx_cell_start}, 0);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      chk(!tx_cell_start && !cell_aligned, "R2 inactive quiet", tx_cell_start, 0);
    end
    mode = 1'b0; sync = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) pipe[i] = IDLE;
    rst = 1'b1; mode = 1'b1; sync = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!tx_cell_start && !cell_aligned && tx_word == IDLE, "R1 reset state", tx_word, IDLE);
    end
    rst = 1'b0; mode = 1'b0;
    inj_en = 1'b1; inj_word = AW1; inj_cclk = 1'b1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      chk(!tx_cell_start && !cell_aligned && tx_word == IDLE, "R2 mode low ignores rx",
          tx_word, IDLE);
    end
    mode = 1'b1; sync = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      chk(!tx_cell_start && !cell_aligned && tx_word == IDLE, "R2 sync low ignores rx",
          tx_word, IDLE);
    end
    mode = 1'b0; inj_en = 1'b0;
    repeat (20) @(negedge clk);
    for (int m = 0; m < L; m++)
      for (int d = 1; d <= 12; d++)
        run_one(m, d, ((m + d) % 2) == 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule